// File: doc/BRIEF.md
# Serial Byte Receiver with Overrun Tracking

This block turns an asynchronous serial line into bytes. Every frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Each finished byte goes into a single holding register that a bus master reads. A receive-full flag shows that the holding register has unread data. An overrun flag shows that at least one byte was lost because the holding register was still full. An interrupt request and a DMA request are derived from these two flags.

A free-running integer divider makes a sample tick. One control input chooses 16 or 8 ticks per bit. The 8x setting allows a higher bit rate for a given clock. The 16x setting tolerates more clock mismatch between the two ends.

The bus side reads the flags through a one-cycle status-read strobe and reads the holding register through a one-cycle data-read strobe. The overrun flag is cleared only by a status read followed later by a data read.

Top module: `uart_rx_ovr`

## Requirements
- R1: With `os8_i`=0, a frame (low start bit, 8 data bits least significant bit first, high stop bit, 16·(`div_i`+1) clocks per bit) that arrives while the receive-full flag is clear appears on `rdata_o`, and `rne_o` goes to 1.
- R2: With `os8_i`=1, a frame at 8·(`div_i`+1) clocks per bit is received the same way.
- R3: `rdata_o` changes only when a byte completes while `rne_o` is 0. Each such transfer sets `rne_o`.
- R4: If a byte completes while `rne_o` is 1, `ovr_o` is set, `rdata_o` keeps the older byte, and the new byte is discarded. This also applies while a DMA request is pending.
- R5: A data-read strobe clears `rne_o` in the next cycle. If a byte completes in the cycle of that read, `rne_o` ends at 0, `ovr_o` at 1, and `rdata_o` keeps the older byte.
- R6: `ovr_o` stays set until a data read that follows a status read made while `ovr_o` was 1. A data read with no such status read leaves it set.
- R7: If a byte completes between a status read (made while `ovr_o` was 0) and the next data read, then after that data read `rne_o`=0 and `ovr_o`=1.
- R8: `irq_o` = (`rne_o` AND `rx_ie_i`) OR (`ovr_o` AND (`rx_ie_i` OR (`err_ie_i` AND `dma_en_i`))).
- R9: `dma_req_o` = `rne_o` AND `dma_en_i`.
- R10: A low pulse on the line that covers fewer sample ticks than half a bit (8 in 16x mode, 4 in 8x mode) is not taken as a start bit, and no byte results.
- R11: A frame whose stop-bit sample is low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R12: The sample tick occurs once every `div_i`+1 clocks, so one bit lasts samples-per-bit × (`div_i`+1) clocks.
- R13: After reset, `rne_o`, `ovr_o`, `irq_o` and `dma_req_o` are 0, and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| os8_i | input | 1 | 0: 16 samples per bit; 1: 8 samples per bit |
| div_i | input | DIV_W | Tick divider; one tick every div_i+1 clocks |
| rd_stat_i | input | 1 | One-cycle status-read strobe |
| rd_data_i | input | 1 | One-cycle data-read strobe |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| dma_en_i | input | 1 | DMA receive enable |
| rdata_o | output | DATA_W | Holding register |
| rne_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The bound checker watches the holding register and both flags on every cycle, using the frame sequencer's internal completion pulse. It checks that a load happens only into an empty register, that a completion into a full register sets overrun without touching the data, that a read empties the register, that overrun is sticky, and that the interrupt and DMA outputs are consistent with the flags. The bench scenarios cover what depends on timing at the line. This includes byte recovery at both oversampling ratios and several divider values across all byte values, rejection of a short low glitch and of a bad stop bit, and the status-then-data clearing order. A sweep moves a data read across the exact cycle in which a byte completes, to show the outcomes before, during and after that cycle.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial byte receiver.
package uart_rx_pkg;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_t;

    // Samples per bit for the selected oversampling ratio.
    function automatic logic [4:0] samples_per_bit(input logic os8);
        return os8 ? 5'd8 : 5'd16;
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for an asynchronous level input.
// Assumes the input is a slow level (serial line); resets to RST_VAL.
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
// Integer sample-tick divider: tick is high one clock in every div_i+1.
// Assumes div_i changes only while the line is idle.
module rx_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = (cnt == div_i);

    // Count clocks and wrap when the tick fires.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_frame.sv
// Frame sequencer: finds the start bit, samples each bit at mid-bit and
// pulses done_o with the assembled byte when the stop bit reads high.
// Assumes rx_i is already synchronized; os8_i is stable during a frame.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              os8_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int BCW = $clog2(DATA_W + 1);

    rx_state_t         state;
    logic [4:0]        scnt;
    logic [BCW-1:0]    bcnt;
    logic [DATA_W-1:0] shreg;
    logic [4:0]        nsamp;
    logic [4:0]        half;
    logic [4:0]        scnt_nx;

    assign nsamp   = samples_per_bit(os8_i);
    assign half    = nsamp >> 1;
    assign scnt_nx = scnt + 5'd1;
    assign data_o  = shreg;

    // Step the frame state machine on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            scnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_i) begin
                            scnt  <= 5'd1;
                            state <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (scnt_nx == half) begin
                            scnt <= '0;
                            bcnt <= '0;
                            state <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            scnt <= scnt_nx;
                        end
                    end
                    ST_DATA: begin
                        if (scnt_nx == nsamp) begin
                            scnt  <= '0;
                            shreg <= {rx_i, shreg[DATA_W-1:1]};
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == BCW'(DATA_W - 1)) state <= ST_STOP;
                        end else begin
                            scnt <= scnt_nx;
                        end
                    end
                    ST_STOP: begin
                        if (scnt_nx == nsamp) begin
                            scnt <= '0;
                            if (rx_i) begin
                                done_o <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                state  <= ST_WAIT_HIGH;
                            end
                        end else begin
                            scnt <= scnt_nx;
                        end
                    end
                    ST_WAIT_HIGH: begin
                        if (rx_i) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_status.sv
// Holding register and flags: loads a byte only into an empty register,
// records overrun otherwise, clears overrun after status-then-data read.
// Assumes done_i is a one-cycle pulse and reads are one-cycle strobes.
module rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_stat_i,
    input  logic              rd_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rne_o,
    output logic              ovr_o
);
    logic armed;
    logic load;
    logic lose;

    assign load = done_i && !rne_o;
    assign lose = done_i && rne_o;

    // Update holding register, full flag, overrun flag and clear arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            rne_o   <= 1'b0;
            ovr_o   <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (load) rdata_o <= data_i;

            if (load)           rne_o <= 1'b1;
            else if (rd_data_i) rne_o <= 1'b0;

            if (lose)                    ovr_o <= 1'b1;
            else if (rd_data_i && armed) ovr_o <= 1'b0;

            if (rd_stat_i)      armed <= ovr_o;
            else if (rd_data_i) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_ovr.sv
// Serial byte receiver top: synchronizer, tick divider, frame sequencer
// and flag logic, plus interrupt and DMA request outputs.
// Assumes configuration inputs change only while the line is idle.
module uart_rx_ovr #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os8_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              rd_stat_i,
    input  logic              rd_data_i,
    input  logic              rx_ie_i,
    input  logic              err_ie_i,
    input  logic              dma_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rne_o,
    output logic              ovr_o,
    output logic              irq_o,
    output logic              dma_req_o
);
    logic              rx_s;
    logic              tick;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;

    rx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
    );

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .tick_o(tick)
    );

    rx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
        .os8_i(os8_i), .done_o(frm_done), .data_o(frm_data)
    );

    rx_status #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .done_i(frm_done), .data_i(frm_data),
        .rd_stat_i(rd_stat_i), .rd_data_i(rd_data_i),
        .rdata_o(rdata_o), .rne_o(rne_o), .ovr_o(ovr_o)
    );

    // Request outputs derived from the flags and enables.
    assign irq_o     = (rne_o && rx_ie_i) || (ovr_o && (rx_ie_i || (err_ie_i && dma_en_i)));
    assign dma_req_o = rne_o && dma_en_i;
endmodule

// File: rtl/rx_chk.sv
// Cycle-level checker for the receiver flags, bound to the top module.
module rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic [DATA_W-1:0] data_i,
    input logic              rd_data_i,
    input logic              rx_ie_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rne_o,
    input logic              ovr_o,
    input logic              irq_o,
    input logic              dma_req_o
);
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !rne_o |=> rne_o && (rdata_o == $past(data_i)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i && !rne_o) |=> $stable(rdata_o));

    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && rne_o |=> ovr_o && $stable(rdata_o));

    p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_i && !done_i |=> !rne_o);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o && !rd_data_i |=> ovr_o);

    p_irq_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o && rx_ie_i |-> irq_o);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rne_o && !ovr_o |-> !irq_o);

    p_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> rne_o);
endmodule

bind uart_rx_ovr rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done_i(frm_done), .data_i(frm_data),
    .rd_data_i(rd_data_i), .rx_ie_i(rx_ie_i), .rdata_o(rdata_o),
    .rne_o(rne_o), .ovr_o(ovr_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
);

// File: tb/sim_uart_rx_ovr.sv
module sim_uart_rx_ovr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        os8 = 1'b0;
    logic [11:0] div = '0;
    logic        rd_stat = 1'b0;
    logic        rd_data = 1'b0;
    logic        rx_ie = 1'b0;
    logic        err_ie = 1'b0;
    logic        dma_en = 1'b0;
    logic [7:0]  rdata;
    logic        rne, ovr, irq, dma_req;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_rx_ovr u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os8_i(os8), .div_i(div),
        .rd_stat_i(rd_stat), .rd_data_i(rd_data), .rx_ie_i(rx_ie),
        .err_ie_i(err_ie), .dma_en_i(dma_en), .rdata_o(rdata),
        .rne_o(rne), .ovr_o(ovr), .irq_o(irq), .dma_req_o(dma_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_clks();
        return (os8 ? 8 : 16) * (int'(div) + 1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Called at a negedge; drives one frame then two idle bit times.
    task automatic send(input logic [7:0] b, input bit stop_hi);
        int bc = bit_clks();
        rx = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (bc) @(negedge clk);
        end
        rx = stop_hi;
        repeat (bc) @(negedge clk);
        rx = 1'b1;
        repeat (2 * bc) @(negedge clk);
    endtask

    task automatic pulse_stat();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
    endtask

    task automatic pulse_data();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    // R8, R9: sweep all enable combinations against the known flag state.
    task automatic irq_sweep(input bit rne_e, input bit ovr_e);
        for (int c = 0; c < 8; c++) begin
            rx_ie = c[0]; err_ie = c[1]; dma_en = c[2];
            #1;
            chk("R8 irq", int'(irq),
                int'((rne_e && c[0]) || (ovr_e && (c[0] || (c[1] && c[2])))));
            chk("R9 dma_req", int'(dma_req), int'(rne_e && c[2]));
        end
        rx_ie = 0; err_ie = 0; dma_en = 0;
        @(negedge clk);
    endtask

    // R1, R2, R3, R12: receive bytes and drain each one.
    task automatic sweep(input bit o8, input int dv, input int step, input string req);
        os8 = o8; div = 12'(dv);
        do_reset();
        for (int b = 0; b < 256; b += step) begin
            send(8'(b), 1'b1);
            chk({req, " R3 data"}, int'(rdata), b);
            chk({req, " R3 rne set"}, int'(rne), 1);
            pulse_data();
            chk("R5 rne cleared by read", int'(rne), 0);
        end
        chk("R4 no overrun in drained stream", int'(ovr), 0);
    endtask

    // R5: one run; k<0 measures the cycle in which overrun appears.
    task automatic ov_run(input int k, output int mo);
        int t0;
        mo = 0;
        do_reset();
        send(8'h5A, 1'b1);
        t0 = cyc;
        fork
            send(8'hC3, 1'b1);
            begin
                if (k >= 0) begin
                    while (cyc - t0 != k) @(negedge clk);
                    pulse_data();
                end else begin
                    while (!ovr) @(negedge clk);
                    mo = cyc - t0;
                end
            end
        join
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int mo;
        int dummy;
        os8 = 1'b0; div = 12'd1;
        do_reset();
        // R13 reset state
        chk("R13 rne", int'(rne), 0);
        chk("R13 ovr", int'(ovr), 0);
        chk("R13 irq", int'(irq), 0);
        chk("R13 dma_req", int'(dma_req), 0);
        chk("R13 rdata", int'(rdata), 0);

        sweep(1'b0, 0, 1, "R1");
        sweep(1'b1, 0, 1, "R2");
        sweep(1'b0, 1, 8, "R1 R12");
        sweep(1'b1, 2, 8, "R2 R12");

        // R4, R6, R7, R8, R9 flag sequences at 8x, divider 0
        os8 = 1'b1; div = 12'd0;
        do_reset();
        send(8'hA1, 1'b1);
        irq_sweep(1'b1, 1'b0);
        dma_en = 1'b1;
        #1 chk("R9 pending request", int'(dma_req), 1);
        @(negedge clk);
        send(8'hB2, 1'b1);
        dma_en = 1'b0;
        chk("R4 ovr set", int'(ovr), 1);
        chk("R4 older byte kept", int'(rdata), 8'hA1);
        chk("R4 rne still set", int'(rne), 1);
        pulse_data();
        chk("R6 data read alone keeps ovr", int'(ovr), 1);
        chk("R5 rne cleared", int'(rne), 0);
        irq_sweep(1'b0, 1'b1);
        send(8'hC4, 1'b1);
        chk("R3 load after drain", int'(rdata), 8'hC4);
        chk("R4 ovr stays while unread", int'(ovr), 1);
        pulse_stat();
        chk("R6 status read alone keeps ovr", int'(ovr), 1);
        pulse_data();
        chk("R6 status then data clears ovr", int'(ovr), 0);
        chk("R6 rne cleared", int'(rne), 0);
        irq_sweep(1'b0, 1'b0);
        send(8'hD5, 1'b1);
        pulse_stat();
        send(8'hE6, 1'b1);
        chk("R7 read returns older byte", int'(rdata), 8'hD5);
        pulse_data();
        chk("R7 rne clear", int'(rne), 0);
        chk("R7 ovr set", int'(ovr), 1);
        pulse_stat();
        pulse_data();
        chk("R6 later clear", int'(ovr), 0);

        // R10 short glitch at 16x, divider 1: 10 clocks cover at most 5 ticks
        os8 = 1'b0; div = 12'd1;
        do_reset();
        rx = 1'b0;
        repeat (10) @(negedge clk);
        rx = 1'b1;
        repeat (3 * bit_clks()) @(negedge clk);
        chk("R10 glitch ignored", int'(rne), 0);
        send(8'h3C, 1'b1);
        chk("R10 next frame ok", int'(rdata), 8'h3C);

        // R11 bad stop bit
        do_reset();
        send(8'h33, 1'b0);
        chk("R11 bad frame dropped", int'(rne), 0);
        chk("R11 holding untouched", int'(rdata), 0);
        send(8'h96, 1'b1);
        chk("R11 recovery data", int'(rdata), 8'h96);
        chk("R11 recovery rne", int'(rne), 1);

        // R5 read swept across the completion cycle
        os8 = 1'b0; div = 12'd0;
        ov_run(-1, mo);
        for (int k = mo - 4; k <= mo + 2; k++) begin
            ov_run(k, dummy);
            if (k < mo - 1) begin
                chk("R5 early read: new byte", int'(rdata), 8'hC3);
                chk("R5 early read: rne", int'(rne), 1);
                chk("R5 early read: ovr", int'(ovr), 0);
            end else begin
                chk("R5 coincident/late read: old byte", int'(rdata), 8'h5A);
                chk("R5 coincident/late read: rne", int'(rne), 0);
                chk("R5 coincident/late read: ovr", int'(ovr), 1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule